// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Block

This block gathers the events raised by an SD host engine into two 16-bit status registers and raises one interrupt request line. Every event arrives either as a single-cycle pulse or as a level that is turned into a pulse. Each event sets a sticky bit that stays set until software clears it by writing zero to that bit. The same two registers also show three live levels: the synchronized card-detect input, the DAT0 line and the command-busy signal. Writes do not change these level bits, and they never raise the interrupt.

Each status register has a mask register of the same width. A set mask bit blocks the interrupt for that bit. The interrupt is high while any sticky bit is set whose mask bit is clear. Card insertion and removal events come from the edges of the synchronized card-detect level. The read-buffer-ready and write-buffer-ready flags are set only on the rising edge of the engine's buffer levels. Software can therefore clear such a flag before it drains or fills the buffer, and the flag comes back only when the next block arrives.

Top module: `sdirq_top`

## Requirements
- R1: While reset is held and right after it, all sticky bits read 0, both mask registers read 16'hFFFF and irq is 0.
- R2: Status register 1 (address 0) sets bit 0 one cycle after a pulse on evt_rsp_done, and bit 2 one cycle after a pulse on evt_xfer_done. Both bits stay set afterwards.
- R3: Status register 2 (address 1) sets bit n (n = 0..6) one cycle after a pulse on err_pulse[n]. The bits are, in order: index error, CRC error, end-bit error, timeout, illegal write, illegal read, response timeout. It sets bit 15 one cycle after a pulse on evt_ill_access.
- R4: A write to a status register clears each sticky bit whose write-data bit is 0. Sticky bits whose write-data bit is 1 keep their value.
- R5: When an event arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R6: Register 2 bit 8 (read buffer ready) and bit 9 (write buffer ready) are set only by a 0-to-1 change of rdbuf_lvl or wrbuf_lvl. After a clear, the bit stays 0 while the level stays high, and it sets again on the next rising edge.
- R7: Register 1 bit 5 shows card_det after CD_SYNC_STAGES clock edges. Register 2 bit 7 shows dat0_lvl and bit 14 shows cmd_busy_lvl directly. Writes never change these three bits.
- R8: Register 1 bit 4 (inserted) sets one cycle after bit 5 rises, and bit 3 (removed) sets one cycle after bit 5 falls.
- R9: irq is 1 exactly when some sticky bit is set and its mask bit is 0. Live level bits never raise irq.
- R10: Mask registers sit at address 2 (for register 1) and address 3 (for register 2). They read back the full written value. Status bits that are not defined (register 1 bits 1 and 6..15, register 2 bits 10..13) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_rsp_done | input | 1 | Response complete pulse |
| evt_xfer_done | input | 1 | Data transfer complete pulse |
| err_pulse | input | 7 | Error event pulses, one per error bit |
| evt_ill_access | input | 1 | Illegal access pulse |
| rdbuf_lvl | input | 1 | Read buffer holds a block (level) |
| wrbuf_lvl | input | 1 | Write buffer can accept a block (level) |
| card_det | input | 1 | Asynchronous card-detect level |
| dat0_lvl | input | 1 | DAT0 line level |
| cmd_busy_lvl | input | 1 | Command engine busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0,1 status; 2,3 mask) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: two card-detect synchronizer stages and both masks resetting to all ones. With the default reset masks, the interrupt stays low until the bench opens a mask. This lets the tests show masking and unmasking on their own. With the two-stage synchronizer, the live card-detect bit and the insert and remove events fall on cycles the bench can count exactly. Random clearing writes that land in the same cycle as events reach the set-wins rule many times. Buffer levels held high across clears test the edge-only setting.

// File: rtl/sdirq_pkg.sv
`timescale 1ns/1ps
package sdirq_pkg;
  localparam int REG_W = 16;
  localparam int ERR_W = 7;

  // register 1 bit positions (software decodes these)
  localparam int S1_RSP    = 0;
  localparam int S1_XFER   = 2;
  localparam int S1_REMOVE = 3;
  localparam int S1_INSERT = 4;
  localparam int S1_CDLVL  = 5;

  // register 2 bit positions
  localparam int S2_ERR0   = 0;
  localparam int S2_DAT0   = 7;
  localparam int S2_RDBUF  = 8;
  localparam int S2_WRBUF  = 9;
  localparam int S2_BUSY   = 14;
  localparam int S2_ILLACC = 15;

  localparam logic [REG_W-1:0] S1_STICKY =
    REG_W'((1 << S1_RSP) | (1 << S1_XFER) | (1 << S1_REMOVE) | (1 << S1_INSERT));
  localparam logic [REG_W-1:0] S2_STICKY =
    REG_W'(((1 << ERR_W) - 1) << S2_ERR0) | REG_W'((1 << S2_RDBUF) | (1 << S2_WRBUF) | (1 << S2_ILLACC));

  typedef enum logic [1:0] {
    A_STAT1 = 2'd0,
    A_STAT2 = 2'd1,
    A_MASK1 = 2'd2,
    A_MASK2 = 2'd3
  } reg_addr_e;

  // next value of a sticky register: zero-write clears, event wins
  function automatic logic [REG_W-1:0] sticky_next(
    input logic [REG_W-1:0] cur,
    input logic             wr,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] set,
    input logic [REG_W-1:0] keep
  );
    logic [REG_W-1:0] kept;
    kept = wr ? (cur & wdata) : cur;
    return (kept | set) & keep;
  endfunction

  function automatic logic any_unmasked(
    input logic [REG_W-1:0] stat,
    input logic [REG_W-1:0] mask,
    input logic [REG_W-1:0] keep
  );
    return |(stat & ~mask & keep);
  endfunction
endpackage

// File: rtl/sdirq_rise.sv
`timescale 1ns/1ps
module sdirq_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;

  // R6
  bufedge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_o) |=> ((pulse_o & $past(pulse_o)) == '0));
endmodule

// File: rtl/sdirq_cdsync.sv
`timescale 1ns/1ps
module sdirq_cdsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int SW = (STAGES < 1) ? 1 : STAGES;
  logic [SW-1:0] chain_q;
  logic          last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= raw_i;
      for (int i = 1; i < SW; i++) chain_q[i] <= chain_q[i-1];
      last_q <= chain_q[SW-1];
    end
  end

  assign level_o = chain_q[SW-1];
  assign rise_o  = level_o & ~last_q;
  assign fall_o  = ~level_o & last_q;

  // R8
  cd_rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  // R8
  cd_fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sdirq_stat.sv
`timescale 1ns/1ps
module sdirq_stat #(
  parameter int                        W    = 16,
  parameter logic [W-1:0]              KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sdirq_pkg::sticky_next(q, wr_i, wdata_i, set_i, KEEP);
  end

  assign q_o = q;

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & KEEP)) |=> ((q & $past(set_i & KEEP)) == $past(set_i & KEEP)));
  // R4
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (($past(q) & ~q) == '0));
  // R4
  one_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (wdata_i == '1)) |=> (($past(q) & ~q) == '0));
endmodule

// File: rtl/sdirq_top.sv
`timescale 1ns/1ps
module sdirq_top #(
  parameter int          CD_SYNC_STAGES = 2,
  parameter logic [15:0] MASK_RESET     = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_rsp_done,
  input  logic        evt_xfer_done,
  input  logic [6:0]  err_pulse,
  input  logic        evt_ill_access,
  input  logic        rdbuf_lvl,
  input  logic        wrbuf_lvl,
  input  logic        card_det,
  input  logic        dat0_lvl,
  input  logic        cmd_busy_lvl,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  import sdirq_pkg::*;

  logic             cd_level, cd_rise, cd_fall;
  logic [1:0]       buf_pulse;
  logic [REG_W-1:0] set1, set2, st1, st2, mask1_q, mask2_q;
  logic             wr_st1, wr_st2;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(reg_addr);

  sdirq_cdsync #(.STAGES(CD_SYNC_STAGES)) u_cd (
    .clk(clk), .rst_n(rst_n), .raw_i(card_det),
    .level_o(cd_level), .rise_o(cd_rise), .fall_o(cd_fall)
  );

  sdirq_rise #(.W(2)) u_buf (
    .clk(clk), .rst_n(rst_n), .lvl_i({wrbuf_lvl, rdbuf_lvl}), .pulse_o(buf_pulse)
  );

  always_comb begin
    set1 = '0;
    set1[S1_RSP]    = evt_rsp_done;
    set1[S1_XFER]   = evt_xfer_done;
    set1[S1_REMOVE] = cd_fall;
    set1[S1_INSERT] = cd_rise;
    set2 = '0;
    set2[S2_ERR0 +: ERR_W] = err_pulse;
    set2[S2_RDBUF]  = buf_pulse[0];
    set2[S2_WRBUF]  = buf_pulse[1];
    set2[S2_ILLACC] = evt_ill_access;
  end

  assign wr_st1 = reg_wr && (addr == A_STAT1);
  assign wr_st2 = reg_wr && (addr == A_STAT2);

  sdirq_stat #(.W(REG_W), .KEEP(S1_STICKY)) u_st1 (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_st1), .wdata_i(reg_wdata), .set_i(set1), .q_o(st1)
  );

  sdirq_stat #(.W(REG_W), .KEEP(S2_STICKY)) u_st2 (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_st2), .wdata_i(reg_wdata), .set_i(set2), .q_o(st2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1_q <= MASK_RESET;
      mask2_q <= MASK_RESET;
    end else if (reg_wr) begin
      if (addr == A_MASK1) mask1_q <= reg_wdata;
      if (addr == A_MASK2) mask2_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (addr)
      A_STAT1: begin
        reg_rdata = st1;
        reg_rdata[S1_CDLVL] = cd_level;
      end
      A_STAT2: begin
        reg_rdata = st2;
        reg_rdata[S2_DAT0] = dat0_lvl;
        reg_rdata[S2_BUSY] = cmd_busy_lvl;
      end
      A_MASK1: reg_rdata = mask1_q;
      default: reg_rdata = mask2_q;
    endcase
  end

  assign irq = any_unmasked(st1, mask1_q, S1_STICKY) | any_unmasked(st2, mask2_q, S2_STICKY);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask1_q == '1) && (mask2_q == '1)) |-> !irq);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/sim_sdirq_top.sv
`timescale 1ns/1ps
module sim_sdirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_rsp_done = 0, evt_xfer_done = 0, evt_ill_access = 0;
  logic [6:0]  err_pulse = '0;
  logic        rdbuf_lvl = 0, wrbuf_lvl = 0, card_det = 0, dat0_lvl = 0, cmd_busy_lvl = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdirq_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_rsp_done(evt_rsp_done), .evt_xfer_done(evt_xfer_done),
    .err_pulse(err_pulse), .evt_ill_access(evt_ill_access), .rdbuf_lvl(rdbuf_lvl),
    .wrbuf_lvl(wrbuf_lvl), .card_det(card_det), .dat0_lvl(dat0_lvl),
    .cmd_busy_lvl(cmd_busy_lvl), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // bench model, built from the requirements
  localparam logic [15:0] K1 = 16'h001D;
  localparam logic [15:0] K2 = 16'h837F;
  logic [15:0] m_st1 = 0, m_st2 = 0, m_mk1 = 16'hFFFF, m_mk2 = 16'hFFFF;
  logic        m_s1 = 0, m_s2 = 0, m_s3 = 0, m_rdp = 0, m_wrp = 0;

  function automatic logic [15:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_st1 | (16'(m_s2) << 5);
      2'd1: return m_st2 | (16'(dat0_lvl) << 7) | (16'(cmd_busy_lvl) << 14);
      2'd2: return m_mk1;
      default: return m_mk2;
    endcase
  endfunction

  function automatic logic model_irq();
    return ((m_st1 & ~m_mk1) != 0) || ((m_st2 & ~m_mk2) != 0);
  endfunction

  task automatic model_step();
    logic [15:0] s1, s2, n1, n2;
    s1 = 16'(evt_rsp_done) | (16'(evt_xfer_done) << 2) |
         (16'(!m_s2 && m_s3) << 3) | (16'(m_s2 && !m_s3) << 4);
    s2 = 16'(err_pulse) | (16'(rdbuf_lvl && !m_rdp) << 8) |
         (16'(wrbuf_lvl && !m_wrp) << 9) | (16'(evt_ill_access) << 15);
    n1 = (reg_wr && reg_addr == 2'd0) ? (m_st1 & reg_wdata) : m_st1;
    n2 = (reg_wr && reg_addr == 2'd1) ? (m_st2 & reg_wdata) : m_st2;
    m_st1 = (n1 | s1) & K1;
    m_st2 = (n2 | s2) & K2;
    if (reg_wr && reg_addr == 2'd2) m_mk1 = reg_wdata;
    if (reg_wr && reg_addr == 2'd3) m_mk2 = reg_wdata;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = card_det;
    m_rdp = rdbuf_lvl; m_wrp = wrbuf_lvl;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1;
    chk(tag, 16'(irq), 16'(exp));
  endtask

  // one clock: model follows the design's edge, then inputs are released
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    evt_rsp_done = 0; evt_xfer_done = 0; evt_ill_access = 0; err_pulse = '0; reg_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20160218));
    repeat (3) @(negedge clk);
    rd_chk("R1 stat1 in reset", 2'd0, 16'h0000);
    rd_chk("R1 mask1 in reset", 2'd2, 16'hFFFF);
    rd_chk("R1 mask2 in reset", 2'd3, 16'hFFFF);
    irq_chk("R1 irq in reset", 1'b0);
    rst_n = 1;
    cycle();
    rd_chk("R1 stat2 after reset", 2'd1, 16'h0000);

    evt_rsp_done = 1; cycle();
    rd_chk("R2 response bit0", 2'd0, 16'h0001);
    evt_xfer_done = 1; cycle();
    rd_chk("R2 transfer bit2", 2'd0, 16'h0005);

    wr(2'd0, 16'hFFFE); cycle();
    rd_chk("R4 zero clears", 2'd0, 16'h0004);
    wr(2'd0, 16'hFFFF); cycle();
    rd_chk("R4 one keeps", 2'd0, 16'h0004);

    err_pulse = 7'h41; evt_ill_access = 1; cycle();
    rd_chk("R3 errors and illegal access", 2'd1, 16'h8041);

    wr(2'd1, 16'h0000); err_pulse = 7'h02; cycle();
    rd_chk("R5 event beats clear", 2'd1, 16'h0002);

    wr(2'd3, 16'hFFFD); cycle();
    rd_chk("R10 mask2 readback", 2'd3, 16'hFFFD);
    irq_chk("R9 unmasked crc raises irq", 1'b1);

    dat0_lvl = 1; cmd_busy_lvl = 1;
    rd_chk("R7 live dat0 and busy", 2'd1, 16'h4082);
    wr(2'd1, 16'h0000); cycle();
    rd_chk("R7 write leaves live bits", 2'd1, 16'h4080);
    irq_chk("R9 live bits give no irq", 1'b0);
    wr(2'd1, 16'hFFFF); cycle();
    rd_chk("R7 ones do not set bits", 2'd1, 16'h4080);
    dat0_lvl = 0; cmd_busy_lvl = 0;

    rdbuf_lvl = 1; cycle();
    rd_chk("R6 read buffer edge", 2'd1, 16'h0100);
    wr(2'd1, 16'h0000); cycle();
    rd_chk("R6 clear with level high", 2'd1, 16'h0000);
    cycle();
    rd_chk("R6 level alone does not set", 2'd1, 16'h0000);
    rdbuf_lvl = 0; cycle();
    rdbuf_lvl = 1; cycle();
    rd_chk("R6 new block sets again", 2'd1, 16'h0100);
    wrbuf_lvl = 1; cycle();
    rd_chk("R6 write buffer edge", 2'd1, 16'h0300);
    wr(2'd1, 16'h0000); cycle();
    rdbuf_lvl = 0; wrbuf_lvl = 0;

    wr(2'd0, 16'h0000); cycle();
    rd_chk("R8 stat1 cleared", 2'd0, 16'h0000);
    card_det = 1; cycle();
    rd_chk("R7 cd after one edge", 2'd0, 16'h0000);
    cycle();
    rd_chk("R7 cd live after sync", 2'd0, 16'h0020);
    cycle();
    rd_chk("R8 inserted", 2'd0, 16'h0030);
    card_det = 0; cycle();
    rd_chk("R8 still present", 2'd0, 16'h0030);
    cycle();
    rd_chk("R8 live dropped", 2'd0, 16'h0010);
    cycle();
    rd_chk("R8 removed", 2'd0, 16'h0018);

    wr(2'd2, 16'h1234); cycle();
    rd_chk("R10 mask1 readback", 2'd2, 16'h1234);
    irq_chk("R9 removed bit unmasked", 1'b1);

    for (int n = 0; n < 4000; n++) begin
      evt_rsp_done   = ($urandom % 8) == 0;
      evt_xfer_done  = ($urandom % 8) == 0;
      evt_ill_access = ($urandom % 16) == 0;
      err_pulse      = (($urandom % 4) == 0) ? 7'($urandom) : 7'd0;
      if (($urandom % 6) == 0) rdbuf_lvl = ~rdbuf_lvl;
      if (($urandom % 6) == 0) wrbuf_lvl = ~wrbuf_lvl;
      if (($urandom % 16) == 0) card_det = ~card_det;
      dat0_lvl     = $urandom % 2;
      cmd_busy_lvl = $urandom % 2;
      reg_addr     = 2'($urandom);
      reg_wr       = ($urandom % 3) == 0;
      reg_wdata    = 16'($urandom);
      #1;
      chk("R10 random read", reg_rdata, model_read(reg_addr));
      chk("R9 random irq", 16'(irq), 16'(model_irq()));
      cycle();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule